// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns their full 16-bit product. It first forms every partial-product bit by ANDing one bit of each operand. The partial products are then reduced in two levels of 4:2 compressors. The first level folds the eight rows into two sum rows and two carry rows. The second level folds those four rows into a single sum row and a single carry row.

Each compressor passes its carry-out sideways into the compressor one column higher in the same level. That carry-out does not depend on the compressor's own carry-in, so the sideways chain never ripples more than one column. A 16-bit Kogge-Stone prefix adder then adds the last two rows. It works in three steps: it forms bit generate and propagate terms, combines them through four prefix levels, and XORs the carries into the sum.

The product leaves the block through a register that has an asynchronous clear. A parameter can drop this register and give a purely combinational path.

Top module: `cmp_tree_mul`

## Requirements
- R1: One clock edge after operands are presented, the output `prod` equals `a * b`, the exact unsigned product, over all 8-bit inputs.
- R2: While `rst_n` is low, `prod` reads 0. In the first cycle after release, it still reads 0 until the first capture edge with reset high.
- R3: The registered output (the default configuration) has exactly one cycle of latency. A new operand pair replaces the previous product at the next rising edge.
- R4: Every 4:2 compressor keeps its weights. Its sum output plus twice the sum of its carry and carry-out equals the count of ones among its four operand bits and its carry-in.
- R5: After the two compressor levels, the remaining sum row plus the remaining carry row equals `a * b` modulo 2^16.
- R6: The prefix adder's result equals the sum of its two input rows modulo 2^16, with carry-in 0.
- R7: With both operands at 255, `prod` is 65025 (0xFE01).
- R8: A single-bit operand 2^i multiplied by a single-bit operand 2^j gives a product with only bit i+j set.
- R9: A zero on either operand gives a zero product, whatever the other operand holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous clear of the output register |
| a | input | 8 | Multiplicand |
| b | input | 8 | Multiplier |
| prod | output | 16 | Product, registered by default |

## Verification
A new operand pair is driven in the same cycle that the product of the previous pair appears. Back-to-back vectors therefore test two things at once: capture of the new inputs, and correct presentation of the old result. The bench changes the operands on every cycle without gaps, and at each cycle it compares `prod` against the product a queue recorded for the operands of the cycle before. Reset release is the other overlap. The first capture edge after release must take in real operands while the cleared value is still on the output, so the bench checks both the zero and the following product.

// File: rtl/cmp_tree_mul.sv
module cmp_tree_mul #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW  = 2 * W;
  localparam int LVL = $clog2(PW);

  logic [PW-1:0] row [8];
  logic [PW-1:0] jin [3][4];
  logic [PW-1:0] sm  [3];
  logic [PW-1:0] cyr [3];
  logic [PW-1:0] cor [3];
  logic [PW-1:0] cy  [3];

  for (genvar i = 0; i < 8; i++) begin : g_pp
    assign row[i] = PW'(a & {W{b[i]}}) << i;
  end

  for (genvar n = 0; n < 4; n++) begin : g_conn
    assign jin[0][n] = row[n];
    assign jin[1][n] = row[4+n];
  end
  assign jin[2][0] = sm[0];
  assign jin[2][1] = cy[0];
  assign jin[2][2] = sm[1];
  assign jin[2][3] = cy[1];

  for (genvar k = 0; k < 3; k++) begin : g_lvl
    assign cy[k] = {cyr[k][PW-2:0], 1'b0};
    for (genvar c = 0; c < PW; c++) begin : g_col
      logic j1, j2, j3, j4, ci, x1, x2, x;
      assign j1 = jin[k][0][c];
      assign j2 = jin[k][1][c];
      assign j3 = jin[k][2][c];
      assign j4 = jin[k][3][c];
      if (c == 0) begin : g_c0
        assign ci = 1'b0;
      end else begin : g_cn
        assign ci = cor[k][c-1];
      end
      assign x1 = j1 ^ j2;
      assign x2 = j3 ^ j4;
      assign x  = x1 ^ x2;
      assign cor[k][c] = x1 ? j3 : j1;
      assign sm[k][c]  = x ^ ci;
      assign cyr[k][c] = x ? ci : j4;

      a_r4_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (3'(j1) + 3'(j2) + 3'(j3) + 3'(j4) + 3'(ci)) ==
        (3'(sm[k][c]) + 3'(2) * (3'(cyr[k][c]) + 3'(cor[k][c]))));
    end
  end

  logic [PW-1:0] g [LVL+1];
  logic [PW-1:0] p [LVL+1];
  logic [PW-1:0] ksum;

  assign g[0] = sm[2] & cy[2];
  assign p[0] = sm[2] ^ cy[2];

  for (genvar l = 0; l < LVL; l++) begin : g_pfx
    for (genvar i = 0; i < PW; i++) begin : g_bit
      if (i >= (1 << l)) begin : g_cell
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-(1<<l)]);
        assign p[l+1][i] = p[l][i] & p[l][i-(1<<l)];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  assign ksum = p[0] ^ {g[LVL][PW-2:0], 1'b0};

  a_r5_two_rows: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(sm[2] + cy[2]) == PW'(PW'(a) * PW'(b)));

  a_r6_prefix_add: assert property (@(posedge clk) disable iff (!rst_n)
    ksum == PW'(sm[2] + cy[2]));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= ksum;
    end

    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |=> prod == PW'($past(PW'(a) * PW'(b))));

    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> prod == '0);
  end else begin : g_comb
    assign prod = ksum;
  end
endmodule

// File: tb/cmp_tree_mul_bench.sv
`timescale 1ns/1ps
module cmp_tree_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] prod;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int unsigned expq [$];
  string       tagq [$];

  cmp_tree_mul u_cmp_tree_mul (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(prod));

  always #2 clk = ~clk;

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: prod=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] na, input logic [7:0] nb, input string tag);
    @(negedge clk);
    if (expq.size() > 0) check(tagq.pop_front(), prod, expq.pop_front());
    a = na;
    b = nb;
    expq.push_back(int'(na) * int'(nb));
    tagq.push_back(tag);
  endtask

  initial begin
    @(negedge clk);
    a = 8'hA5; b = 8'h3C;
    check("R2 in reset", prod, 0);
    @(negedge clk);
    check("R2 held in reset", prod, 0);
    rst_n = 1'b1;
    a = 8'h11; b = 8'h07;
    expq.push_back(int'(8'h11) * int'(8'h07));
    tagq.push_back("R3 first capture");
    #1 check("R2 after release before edge", prod, 0);
    step(8'h00, 8'h00, "R9 both zero");
    step(8'h00, 8'hFF, "R9 a zero");
    step(8'hC3, 8'h00, "R9 b zero");
    step(8'hFF, 8'hFF, "R7 all ones");
    step(8'h01, 8'h01, "R8 unit");
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        step(8'(1 << i), 8'(1 << j), "R8 single bit");
    step(8'hFF, 8'h01, "R3 back to back");
    step(8'h01, 8'hFF, "R3 back to back");
    for (int n = 0; n < 400; n++)
      step(8'($urandom), 8'($urandom), "R1 R4 R5 R6 random");
    for (int n = 0; n < 256; n++)
      step(8'(n), 8'(255 - n), "R1 sweep");
    step(8'h00, 8'h00, "R9 drain");
    @(negedge clk);
    check(tagq.pop_front(), prod, expq.pop_front());
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: prod=%0h expected=done", prod);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule